// File: doc/BRIEF.md
# I2C FIFO Threshold Event Unit

This block sits between the register side of an I2C master and its byte engine. It holds one byte FIFO for outgoing data and one for incoming data. It tracks how many bytes of the current transfer are still outstanding in each direction, and turns FIFO levels, engine indications and programmable thresholds into sticky status events. Each event can be masked and leads to a single interrupt line. Software reaches everything through a small 16-bit register port: control, byte count, buffer configuration, status, enable set, enable clear, data, FIFO information and levels.

A transfer is controlled by a three-state machine. `XS_IDLE` moves to `XS_TX` (transition START_TX) or `XS_RX` (transition START_RX) when control is written with the go bit, the enable bit and the master bit all set, and the stored count is nonzero. The transmit bit picks between the two. Either busy state returns to `XS_IDLE` when the engine reports that the transfer is done (FINISH) or when a control write clears the enable bit (ABORT). In `XS_TX`, the ready event asks software for a full threshold's worth of bytes. The draining event asks for the last few bytes, when fewer than a threshold remain. `XS_RX` works the same way for received bytes.

Register map (addresses, 4-bit): 0 control, 1 count, 2 buffer configuration, 3 status, 4 enable set, 5 enable clear, 6 data, 7 FIFO info, 8 levels (TX level in [7:0], RX level in [15:8]).

Top module: `i2c_fifo_event_unit`

## Requirements
- R1: A threshold field holding value f means a threshold of f+1. With the RX field at 0, a single received byte raises RX-ready (status bit 3).
- R2: In `XS_RX`, RX-ready (status bit 3) sets one cycle after the RX FIFO level first becomes at least the RX threshold. The RX threshold field is buffer-configuration bits [13:8].
- R3: In `XS_RX`, RX-draining (status bit 5) sets when no bytes of the transfer remain to be received, the RX FIFO is not empty, and its level is below the RX threshold.
- R4: In `XS_TX`, TX-ready (status bit 4) sets when the TX FIFO level is below the TX threshold and the bytes software still has to write are at least the threshold. The TX threshold field is buffer-configuration bits [5:0].
- R5: In `XS_TX`, TX-draining (status bit 6) sets when the TX level is below the threshold and the bytes still to be written are nonzero but fewer than the threshold.
- R6: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event sets only on the rising edge of its condition.
- R7: Writing 1s to enable-set (address 4) sets enables, and writing 1s to enable-clear (address 5) clears them. Both addresses read back the enables. `irq` is high exactly when some status bit and its enable are both 1.
- R8: The engine's NACK and arbitration-lost pulses set status bits 1 and 0. A done pulse while busy sets access-ready (bit 2) and returns the machine to `XS_IDLE`.
- R9: In control, bit 15 enables the unit, bit 10 selects master, bit 9 selects transmit (1) or receive (0), and bit 0 is a go bit that always reads 0. A go without enable or without master does not start a transfer.
- R10: Buffer-configuration bit 6 flushes the TX FIFO and bit 14 flushes the RX FIFO. The level is 0 one clock after the write, and the flush bits read back as 0.
- R11: FIFO-info bits [2:0] read the depth code n, where the FIFO depth is 8<<n bytes.
- R12: A go with a stored count of 0 is ignored, and the machine stays in `XS_IDLE`.
- R13: Reading data while the RX FIFO is empty returns 0 and changes nothing. A data write to a full TX FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops RX on the data address) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| eng_tx_pop | input | 1 | Engine takes the TX head byte |
| eng_tx_data | output | 8 | TX FIFO head byte |
| eng_tx_empty | output | 1 | TX FIFO empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_nack | input | 1 | No-acknowledge pulse |
| eng_arb_lost | input | 1 | Arbitration-lost pulse |
| eng_done | input | 1 | Transfer-complete pulse |
| xfer_active | output | 1 | Machine is in `XS_TX` or `XS_RX` |
| xfer_is_tx | output | 1 | Machine is in `XS_TX` |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the unit with DEPTH_CODE = 0 (an 8-byte FIFO) and CNT_W = 16. The small depth means a full TX FIFO and a dropped ninth byte take only nine writes. Thresholds of 2 and 4 fit inside that depth, so a 9-byte transmit and a 5-byte receive each reach both the ready and the draining events. Each event is seen firing again after software or the engine moves the level back across the threshold.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_TX   = 2'd1,
        XS_RX   = 2'd2
    } xfer_state_e;

    localparam int REG_W = 16;
    localparam int THR_W = 6;

    // register addresses
    localparam logic [3:0] A_CTL  = 4'd0;
    localparam logic [3:0] A_CNT  = 4'd1;
    localparam logic [3:0] A_BUF  = 4'd2;
    localparam logic [3:0] A_STAT = 4'd3;
    localparam logic [3:0] A_IES  = 4'd4;
    localparam logic [3:0] A_IEC  = 4'd5;
    localparam logic [3:0] A_DAT  = 4'd6;
    localparam logic [3:0] A_INF  = 4'd7;
    localparam logic [3:0] A_LVL  = 4'd8;

    // control bits
    localparam int CTL_EN_BIT  = 15;
    localparam int CTL_MST_BIT = 10;
    localparam int CTL_TX_BIT  = 9;
    localparam int CTL_GO_BIT  = 0;

    // buffer configuration layout
    localparam int BUF_TX_LSB   = 0;
    localparam int BUF_TXFL_BIT = 6;
    localparam int BUF_RX_LSB   = 8;
    localparam int BUF_RXFL_BIT = 14;

    // event indices
    localparam int EV_AL   = 0;
    localparam int EV_NACK = 1;
    localparam int EV_ARDY = 2;
    localparam int EV_RRDY = 3;
    localparam int EV_XRDY = 4;
    localparam int EV_RDR  = 5;
    localparam int EV_XDR  = 6;
    localparam int NEV     = 7;
endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
    parameter int DEPTH_CODE = 0,
    parameter int DW         = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   flush,
    input  logic                                   push,
    input  logic [DW-1:0]                          push_data,
    input  logic                                   pop,
    output logic [DW-1:0]                          head,
    output logic [$clog2(8 << DEPTH_CODE):0]       level,
    output logic                                   full,
    output logic                                   empty
);
    localparam int DEPTH = 8 << DEPTH_CODE;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    assert_drop_full_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == $past(level)));
    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
endmodule

// File: rtl/i2cfe_events.sv
module i2cfe_events #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic         clr_we,
    input  logic         ie_set_we,
    input  logic         ie_clr_we,
    input  logic [N-1:0] wmask,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         irq
);
    logic [N-1:0] raw_q;
    logic [N-1:0] rise;

    assign rise = raw & ~raw_q;
    assign irq  = |(status & enable);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            status <= '0;
            enable <= '0;
        end else begin
            raw_q <= raw;
            // a new event wins over a clear in the same cycle
            status <= (status & ~(clr_we ? wmask : '0)) | rise;
            if (ie_set_we)      enable <= enable | wmask;
            else if (ie_clr_we) enable <= enable & ~wmask;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_chk
        assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (status[k] && !(clr_we && wmask[k])) |=> status[k]);
        assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wmask[k] && !raw[k]) |=> !status[k]);
    end

    assert_ie_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set_we |=> ((enable & $past(wmask)) == $past(wmask)));
    assert_ie_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_clr_we && !ie_set_we) |=> ((enable & $past(wmask)) == '0));
endmodule

// File: rtl/i2c_fifo_event_unit.sv
module i2c_fifo_event_unit
    import i2cfe_pkg::*;
#(
    parameter int DEPTH_CODE = 0,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             eng_tx_pop,
    output logic [7:0]       eng_tx_data,
    output logic             eng_tx_empty,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_data,
    input  logic             eng_nack,
    input  logic             eng_arb_lost,
    input  logic             eng_done,
    output logic             xfer_active,
    output logic             xfer_is_tx,
    output logic             irq
);
    localparam int DEPTH = 8 << DEPTH_CODE;
    localparam int LW    = $clog2(DEPTH) + 1;
    localparam int CW    = CNT_W + 1;

    xfer_state_e state_q, state_d;

    logic             en_q, mst_q, dir_tx_q;
    logic [CNT_W-1:0] cnt_q, tx_left, rx_left;
    logic [THR_W-1:0] tx_thr_f, rx_thr_f;

    logic wr_ctl, wr_cnt, wr_buf, wr_stat, wr_ies, wr_iec, wr_dat, rd_dat;
    logic go_req, start_ok;

    logic [7:0]    rx_head;
    logic [LW-1:0] tx_lvl, rx_lvl;
    logic          tx_full, rx_full, rx_empty;
    logic          tx_push_ok, rx_push_ok;

    logic [NEV-1:0] ev_raw, ev_status, ev_enable;
    logic [CW-1:0]  tx_thr_x, rx_thr_x, tx_lvl_x, rx_lvl_x, tx_left_x;

    // register decode
    assign wr_ctl  = reg_we && (reg_addr == A_CTL);
    assign wr_cnt  = reg_we && (reg_addr == A_CNT);
    assign wr_buf  = reg_we && (reg_addr == A_BUF);
    assign wr_stat = reg_we && (reg_addr == A_STAT);
    assign wr_ies  = reg_we && (reg_addr == A_IES);
    assign wr_iec  = reg_we && (reg_addr == A_IEC);
    assign wr_dat  = reg_we && (reg_addr == A_DAT);
    assign rd_dat  = reg_re && (reg_addr == A_DAT);

    assign go_req   = wr_ctl && reg_wdata[CTL_GO_BIT];
    assign start_ok = go_req && reg_wdata[CTL_EN_BIT] && reg_wdata[CTL_MST_BIT]
                      && (cnt_q != '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: begin
                if (start_ok) state_d = reg_wdata[CTL_TX_BIT] ? XS_TX : XS_RX;
            end
            XS_TX, XS_RX: begin
                if (eng_done)                                  state_d = XS_IDLE;
                else if (wr_ctl && !reg_wdata[CTL_EN_BIT])     state_d = XS_IDLE;
            end
            default: state_d = XS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // state outputs
    always_comb begin
        xfer_active = 1'b0;
        xfer_is_tx  = 1'b0;
        unique case (state_q)
            XS_IDLE: ;
            XS_TX: begin
                xfer_active = 1'b1;
                xfer_is_tx  = 1'b1;
            end
            XS_RX: xfer_active = 1'b1;
            default: ;
        endcase
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            mst_q    <= 1'b0;
            dir_tx_q <= 1'b0;
            cnt_q    <= '0;
            tx_thr_f <= '0;
            rx_thr_f <= '0;
        end else begin
            if (wr_ctl) begin
                en_q     <= reg_wdata[CTL_EN_BIT];
                mst_q    <= reg_wdata[CTL_MST_BIT];
                dir_tx_q <= reg_wdata[CTL_TX_BIT];
            end
            if (wr_cnt) cnt_q <= reg_wdata[CNT_W-1:0];
            if (wr_buf) begin
                tx_thr_f <= reg_wdata[BUF_TX_LSB +: THR_W];
                rx_thr_f <= reg_wdata[BUF_RX_LSB +: THR_W];
            end
        end
    end

    // outstanding byte counters
    assign tx_push_ok = wr_dat && !tx_full;
    assign rx_push_ok = eng_rx_push && !rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_left <= '0;
            rx_left <= '0;
        end else if (state_q == XS_IDLE && start_ok) begin
            tx_left <= cnt_q;
            rx_left <= cnt_q;
        end else begin
            if (state_q == XS_TX && tx_push_ok && tx_left != '0)
                tx_left <= tx_left - CNT_W'(1);
            if (state_q == XS_RX && rx_push_ok && rx_left != '0)
                rx_left <= rx_left - CNT_W'(1);
        end
    end

    // FIFOs
    i2cfe_fifo #(.DEPTH_CODE(DEPTH_CODE), .DW(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .flush(wr_buf && reg_wdata[BUF_TXFL_BIT]),
        .push(wr_dat), .push_data(reg_wdata[7:0]),
        .pop(eng_tx_pop), .head(eng_tx_data),
        .level(tx_lvl), .full(tx_full), .empty(eng_tx_empty)
    );

    i2cfe_fifo #(.DEPTH_CODE(DEPTH_CODE), .DW(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .flush(wr_buf && reg_wdata[BUF_RXFL_BIT]),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_dat), .head(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    // event conditions
    assign tx_thr_x  = CW'(tx_thr_f) + CW'(1);
    assign rx_thr_x  = CW'(rx_thr_f) + CW'(1);
    assign tx_lvl_x  = CW'(tx_lvl);
    assign rx_lvl_x  = CW'(rx_lvl);
    assign tx_left_x = CW'(tx_left);

    always_comb begin
        ev_raw          = '0;
        ev_raw[EV_AL]   = eng_arb_lost;
        ev_raw[EV_NACK] = eng_nack;
        ev_raw[EV_ARDY] = eng_done && (state_q != XS_IDLE);
        ev_raw[EV_RRDY] = (state_q == XS_RX) && (rx_lvl_x >= rx_thr_x);
        ev_raw[EV_RDR]  = (state_q == XS_RX) && (rx_left == '0) && !rx_empty
                          && (rx_lvl_x < rx_thr_x);
        ev_raw[EV_XRDY] = (state_q == XS_TX) && (tx_lvl_x < tx_thr_x)
                          && (tx_left_x >= tx_thr_x);
        ev_raw[EV_XDR]  = (state_q == XS_TX) && (tx_lvl_x < tx_thr_x)
                          && (tx_left != '0) && (tx_left_x < tx_thr_x);
    end

    i2cfe_events #(.N(NEV)) u_events (
        .clk(clk), .rst_n(rst_n), .raw(ev_raw),
        .clr_we(wr_stat), .ie_set_we(wr_ies), .ie_clr_we(wr_iec),
        .wmask(reg_wdata[NEV-1:0]),
        .status(ev_status), .enable(ev_enable), .irq(irq)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTL: begin
                reg_rdata[CTL_EN_BIT]  = en_q;
                reg_rdata[CTL_MST_BIT] = mst_q;
                reg_rdata[CTL_TX_BIT]  = dir_tx_q;
            end
            A_CNT: reg_rdata = REG_W'(cnt_q);
            A_BUF: begin
                reg_rdata[BUF_TX_LSB +: THR_W] = tx_thr_f;
                reg_rdata[BUF_RX_LSB +: THR_W] = rx_thr_f;
            end
            A_STAT:       reg_rdata = REG_W'(ev_status);
            A_IES, A_IEC: reg_rdata = REG_W'(ev_enable);
            A_DAT:        reg_rdata = rx_empty ? '0 : REG_W'(rx_head);
            A_INF:        reg_rdata = REG_W'(3'(DEPTH_CODE));
            A_LVL:        reg_rdata = {8'(rx_lvl), 8'(tx_lvl)};
            default:      reg_rdata = '0;
        endcase
    end

    assert_zero_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_IDLE && go_req && cnt_q == '0) |=> (state_q == XS_IDLE));
    assert_start_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> (en_q && mst_q));
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && eng_done) |=> !xfer_active);
    assert_empty_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && rx_empty) |=> (rx_lvl == $past(rx_lvl) || $past(eng_rx_push)));
    assert_tx_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_TX) |-> (tx_left <= cnt_q));
endmodule

// File: tb/i2c_fifo_event_unit_tb_top.sv
module i2c_fifo_event_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we, reg_re;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        eng_tx_pop, eng_tx_empty, eng_rx_push;
    logic [7:0]  eng_tx_data, eng_rx_data;
    logic        eng_nack, eng_arb_lost, eng_done;
    logic        xfer_active, xfer_is_tx, irq;

    always #5 clk = ~clk;

    i2c_fifo_event_unit #(.DEPTH_CODE(0), .CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_empty(eng_tx_empty), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost), .eng_done(eng_done),
        .xfer_active(xfer_active), .xfer_is_tx(xfer_is_tx), .irq(irq)
    );

    // operations of the vector table
    localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_TXPOP = 4'd2,
                           OP_RX = 4'd3, OP_NACK = 4'd4, OP_AL = 4'd5,
                           OP_DONE = 4'd6, OP_ACT = 4'd7, OP_IRQ = 4'd8;
    localparam logic [3:0] A_CTL = 4'd0, A_CNT = 4'd1, A_BUF = 4'd2,
                           A_STAT = 4'd3, A_IES = 4'd4, A_IEC = 4'd5,
                           A_DAT = 4'd6, A_INF = 4'd7, A_LVL = 4'd8;

    function automatic logic [47:0] v(logic [3:0] op, logic [3:0] a,
                                      logic [15:0] d, logic [15:0] m,
                                      logic [7:0] r);
        return {op, a, d, m, r};
    endfunction

    localparam int NV = 64;
    localparam logic [47:0] VEC [NV] = '{
        v(OP_RD,   A_INF,  16'h0000, 16'h0007, 8'd11), // R11 depth code 0
        v(OP_WR,   A_CNT,  16'h0000, 16'h0000, 8'd0),
        v(OP_WR,   A_CTL,  16'h8601, 16'h0000, 8'd0),
        v(OP_ACT,  A_CTL,  16'h0000, 16'h0001, 8'd12), // R12 zero count ignored
        v(OP_WR,   A_CNT,  16'h0009, 16'h0000, 8'd0),
        v(OP_WR,   A_BUF,  16'h0103, 16'h0000, 8'd0),
        v(OP_WR,   A_CTL,  16'h0601, 16'h0000, 8'd0),
        v(OP_ACT,  A_CTL,  16'h0000, 16'h0001, 8'd9),  // R9 no enable
        v(OP_WR,   A_CTL,  16'h8201, 16'h0000, 8'd0),
        v(OP_ACT,  A_CTL,  16'h0000, 16'h0001, 8'd9),  // R9 no master
        v(OP_WR,   A_CTL,  16'h8601, 16'h0000, 8'd0),
        v(OP_ACT,  A_CTL,  16'h0001, 16'h0001, 8'd9),  // R9 starts
        v(OP_RD,   A_CTL,  16'h8600, 16'hFFFF, 8'd9),  // R9 go reads 0
        v(OP_RD,   A_STAT, 16'h0010, 16'h007F, 8'd4),  // R4 TX-ready at start
        v(OP_IRQ,  A_CTL,  16'h0000, 16'h0001, 8'd7),  // R7 masked
        v(OP_WR,   A_IES,  16'h0010, 16'h0000, 8'd0),
        v(OP_IRQ,  A_CTL,  16'h0001, 16'h0001, 8'd7),  // R7 enabled
        v(OP_RD,   A_IEC,  16'h0010, 16'h007F, 8'd7),  // R7 readback
        v(OP_WR,   A_IEC,  16'h0010, 16'h0000, 8'd0),
        v(OP_IRQ,  A_CTL,  16'h0000, 16'h0001, 8'd7),  // R7 cleared enable
        v(OP_WR,   A_STAT, 16'h0000, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0010, 16'h007F, 8'd6),  // R6 write 0 keeps
        v(OP_WR,   A_STAT, 16'h0010, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0000, 16'h007F, 8'd6),  // R6 write 1 clears
        v(OP_WR,   A_DAT,  16'h00A1, 16'h0000, 8'd0),
        v(OP_WR,   A_DAT,  16'h00A2, 16'h0000, 8'd0),
        v(OP_WR,   A_DAT,  16'h00A3, 16'h0000, 8'd0),
        v(OP_WR,   A_DAT,  16'h00A4, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0000, 16'h007F, 8'd4),  // R4 level at threshold
        v(OP_TXPOP,A_CTL,  16'h0000, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0010, 16'h007F, 8'd4),  // R4 fires again
        v(OP_WR,   A_STAT, 16'h0010, 16'h0000, 8'd0),
        v(OP_WR,   A_DAT,  16'h00A5, 16'h0000, 8'd0),
        v(OP_WR,   A_DAT,  16'h00A6, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0000, 16'h007F, 8'd5),  // R5 level above
        v(OP_TXPOP,A_CTL,  16'h0000, 16'h0000, 8'd0),
        v(OP_TXPOP,A_CTL,  16'h0000, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0040, 16'h007F, 8'd5),  // R5 TX-draining
        v(OP_WR,   A_DAT,  16'h00A7, 16'h0000, 8'd0),
        v(OP_WR,   A_DAT,  16'h00A8, 16'h0000, 8'd0),
        v(OP_WR,   A_DAT,  16'h00A9, 16'h0000, 8'd0),
        v(OP_RD,   A_LVL,  16'h0006, 16'h00FF, 8'd4),  // R4 TX level
        v(OP_DONE, A_CTL,  16'h0000, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0044, 16'h007F, 8'd8),  // R8 access-ready
        v(OP_ACT,  A_CTL,  16'h0000, 16'h0001, 8'd8),  // R8 back to idle
        v(OP_NACK, A_CTL,  16'h0000, 16'h0000, 8'd0),
        v(OP_AL,   A_CTL,  16'h0000, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0047, 16'h007F, 8'd8),  // R8 NACK and AL
        v(OP_WR,   A_STAT, 16'h007F, 16'h0000, 8'd0),
        v(OP_WR,   A_BUF,  16'h0143, 16'h0000, 8'd0),
        v(OP_RD,   A_LVL,  16'h0000, 16'h00FF, 8'd10), // R10 TX flushed
        v(OP_RD,   A_BUF,  16'h0103, 16'hFFFF, 8'd10), // R10 flush bit reads 0
        v(OP_WR,   A_CNT,  16'h0005, 16'h0000, 8'd0),
        v(OP_WR,   A_CTL,  16'h8401, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0000, 16'h007F, 8'd2),  // R2 nothing yet
        v(OP_RX,   A_CTL,  16'h0011, 16'h0000, 8'd0),
        v(OP_RX,   A_CTL,  16'h0022, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0008, 16'h007F, 8'd2),  // R2 RX-ready
        v(OP_RD,   A_DAT,  16'h0011, 16'h00FF, 8'd2),  // R2 data order
        v(OP_RD,   A_DAT,  16'h0022, 16'h00FF, 8'd2),
        v(OP_WR,   A_STAT, 16'h0008, 16'h0000, 8'd0),
        v(OP_RX,   A_CTL,  16'h0033, 16'h0000, 8'd0),
        v(OP_RX,   A_CTL,  16'h0044, 16'h0000, 8'd0),
        v(OP_RD,   A_STAT, 16'h0008, 16'h007F, 8'd2)   // R2 fires again
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string what, input int req, input logic [15:0] act,
                       input logic [15:0] exp, input logic [15:0] mask);
        n_chk++;
        if ((act & mask) !== (exp & mask)) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what,
                     act & mask, exp & mask);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        settle();
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
        settle();
    endtask

    task automatic eng(input logic [3:0] op, input logic [7:0] d);
        @(negedge clk);
        case (op)
            OP_TXPOP: eng_tx_pop   = 1'b1;
            OP_RX:    begin eng_rx_push = 1'b1; eng_rx_data = d; end
            OP_NACK:  eng_nack     = 1'b1;
            OP_AL:    eng_arb_lost = 1'b1;
            default:  eng_done     = 1'b1;
        endcase
        @(negedge clk);
        eng_tx_pop = 1'b0; eng_rx_push = 1'b0; eng_nack = 1'b0;
        eng_arb_lost = 1'b0; eng_done = 1'b0;
        settle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        reg_we = 0; reg_re = 0; reg_addr = '0; reg_wdata = '0;
        eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = '0;
        eng_nack = 0; eng_arb_lost = 0; eng_done = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // reset state
        chk("reset irq", 7, {15'd0, irq}, 16'h0, 16'h1);                 // R7
        chk("reset active", 9, {15'd0, xfer_active}, 16'h0, 16'h1);      // R9
        reg_rd(A_STAT, rv); chk("reset status", 6, rv, 16'h0, 16'hFFFF); // R6
        reg_rd(A_LVL, rv);  chk("reset levels", 10, rv, 16'h0, 16'hFFFF);// R10

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  op, a;
            logic [15:0] d, m;
            logic [7:0]  r;
            {op, a, d, m, r} = VEC[i];
            case (op)
                OP_WR: reg_wr(a, d);
                OP_RD: begin
                    reg_rd(a, rv);
                    chk($sformatf("vector %0d read", i), int'(r), rv, d, m);
                end
                OP_ACT: begin
                    @(negedge clk); #1;
                    chk($sformatf("vector %0d active", i), int'(r),
                        {15'd0, xfer_active}, d, m);
                end
                OP_IRQ: begin
                    @(negedge clk); #1;
                    chk($sformatf("vector %0d irq", i), int'(r),
                        {15'd0, irq}, d, m);
                end
                default: eng(op, d[7:0]);
            endcase
        end

        // directed: RX tail, draining and empty read
        reg_wr(A_STAT, 16'h0008);
        reg_rd(A_DAT, rv); chk("rx byte 3", 2, rv, 16'h0033, 16'h00FF);  // R2
        reg_rd(A_DAT, rv); chk("rx byte 4", 2, rv, 16'h0044, 16'h00FF);  // R2
        reg_rd(A_DAT, rv); chk("empty read value", 13, rv, 16'h0, 16'hFFFF); // R13
        reg_rd(A_LVL, rv); chk("empty read level", 13, rv, 16'h0, 16'hFF00); // R13
        reg_rd(A_STAT, rv); chk("no draining early", 3, rv, 16'h0, 16'h007F); // R3
        eng(OP_RX, 8'h55);
        reg_rd(A_STAT, rv); chk("RX-draining", 3, rv, 16'h0020, 16'h007F); // R3
        eng(OP_DONE, 8'h00);
        reg_rd(A_STAT, rv); chk("rx done", 8, rv, 16'h0024, 16'h007F);   // R8
        reg_rd(A_DAT, rv); chk("last rx byte", 3, rv, 16'h0055, 16'h00FF); // R3
        reg_wr(A_STAT, 16'h007F);

        // directed: threshold of one (field 0)
        reg_wr(A_BUF, 16'h0003);
        reg_wr(A_CNT, 16'h0003);
        reg_wr(A_CTL, 16'h8401);
        eng(OP_RX, 8'h66);
        reg_rd(A_STAT, rv); chk("threshold one", 1, rv, 16'h0008, 16'h007F); // R1
        eng(OP_DONE, 8'h00);
        reg_wr(A_STAT, 16'h007F);
        reg_rd(A_LVL, rv); chk("rx level before flush", 10, rv, 16'h0100, 16'hFF00); // R10
        reg_wr(A_BUF, 16'h4003);
        reg_rd(A_LVL, rv); chk("rx flushed", 10, rv, 16'h0000, 16'hFF00); // R10

        // directed: full TX FIFO drops the extra byte
        for (int k = 1; k <= 9; k++) reg_wr(A_DAT, 16'(k));
        reg_rd(A_LVL, rv); chk("tx full level", 13, rv, 16'h0008, 16'h00FF); // R13
        chk("tx head first", 13, {8'd0, eng_tx_data}, 16'h0001, 16'h00FF);   // R13
        for (int k = 0; k < 7; k++) eng(OP_TXPOP, 8'h00);
        chk("tx last kept", 13, {8'd0, eng_tx_data}, 16'h0008, 16'h00FF);    // R13
        eng(OP_TXPOP, 8'h00);
        chk("ninth dropped", 13, {15'd0, eng_tx_empty}, 16'h0001, 16'h0001); // R13

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule